// File: doc/BRIEF.md
# Line-Paced Audio Timer Bank

This block keeps three small audio timers that are paced by a once-per-scanline tick strobe. Each timer has its own enable and an 8-bit period. When its internal divider completes a period, the timer advances a 4-bit visible counter that the audio side polls.

Two timers are slow. They only see ticks that arrive while the current line number is odd, so they run at half the line rate. Their dividers step by one and restart from zero on every period. The third timer is fast. It adds four to its divider on every tick and takes whole periods out of it one per clock cycle. The leftover is kept, so one tick can yield several counter steps. A busy flag shows that periods are still being taken out.

The block sits beside the line sequencer. The sequencer drives the tick strobe and the line parity. Software-visible registers live elsewhere and drive the enable and period ports directly.

Top module: `line_timer_bank`

## Requirements
- R1: While reset is high and in the cycle after it, every output counter reads 0 and the fast busy flag reads 0.
- R2: Each tick accepted by an enabled fast timer adds 4 to the fast divider.
- R3: While the fast divider is at or above the period, the fast timer removes one period per clock cycle and raises its counter by one each time, keeping the remainder. The busy flag is 1 from the cycle after the tick until the cycle in which the divider drops below the period.
- R4: A slow timer ignores any tick that arrives while `line_odd_i` is 0.
- R5: On each accepted tick, an enabled slow timer adds 1 to its divider. When the sum reaches the period, the counter rises by one and the divider returns to 0.
- R6: Every output counter is 4 bits wide and wraps from 15 to 0.
- R7: A period value of 0 acts as a period of 256.
- R8: While its enable is 0, a timer holds both its divider and its counter.
- R9: In the first cycle its enable is seen high after being low (or after reset), a timer clears its divider and ignores any tick in that cycle. Its counter is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle line tick strobe |
| line_odd_i | input | 1 | 1 when the line number of this tick is odd |
| fast_en_i | input | 1 | Fast timer enable |
| fast_tgt_i | input | 8 | Fast timer period (0 means 256) |
| slow_en_i | input | 2 | Slow timer enables, bit n for slow timer n |
| slow_tgt_i | input | 16 | Slow periods, slow timer n in bits [8n+7:8n] |
| fast_cnt_o | output | 4 | Fast timer counter |
| fast_busy_o | output | 1 | Fast timer still removing periods |
| slow_cnt_o | output | 8 | Slow counters, slow timer n in bits [4n+3:4n] |

## Verification
The bench drives long tick runs with periods of 1, 3, 7, 255 and 0. A fast timer that dropped its remainder, or that allowed only one step per tick, would end with the wrong total. Period 1 makes one tick yield four counter steps, so the busy flag and the one-step-per-cycle pacing can be checked directly. Runs that go past 15 would expose a counter that saturates instead of wrapping.

Even-line ticks are sent to timers with a period of 1, where any wrongly accepted tick would show at once. A timer is also disabled and re-enabled with a partly filled divider. If the divider were not cleared, the next period would end one tick early.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int unsigned TB_TGT_W = 8;
  localparam int unsigned TB_CNT_W = 4;
  localparam int unsigned TB_FAST_STEP = 4;
  localparam int unsigned TB_NUM_SLOW = 2;

  typedef enum logic {
    FT_IDLE  = 1'b0,
    FT_DRAIN = 1'b1
  } fast_state_e;
endpackage

// File: rtl/tick_split.sv
module tick_split (
  input  logic tick_i,
  input  logic line_odd_i,
  output logic fast_tick_o,
  output logic slow_tick_o
);
  always_comb begin
    fast_tick_o = tick_i;
    slow_tick_o = tick_i & line_odd_i;
  end
endmodule

// File: rtl/slow_timer.sv
module slow_timer #(
  parameter int unsigned TGT_W = timer_bank_pkg::TB_TGT_W,
  parameter int unsigned CNT_W = timer_bank_pkg::TB_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned DIV_W = TGT_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_inc;
  logic [DIV_W-1:0] tgt_eff;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             en_rise;

  always_comb begin
    tgt_eff = (tgt_i == '0) ? DIV_W'(1) << TGT_W : {1'b0, tgt_i};
    div_inc = div_q + DIV_W'(1);
    en_rise = en_i & ~en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= en_i;
      if (en_rise) begin
        div_q <= '0;
      end else if (en_i && tick_i) begin
        if (div_inc >= tgt_eff) begin
          div_q <= '0;
          cnt_q <= cnt_q + CNT_W'(1);
        end else begin
          div_q <= div_inc;
        end
      end
    end
  end

  assign cnt_o = cnt_q;

  // R8: a disabled slow timer keeps divider and counter
  p_hold_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ($stable(cnt_q) && $stable(div_q)));

  // R5: every counter step leaves the divider at zero
  p_div_zero_on_step_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q)) |-> (div_q == '0));
endmodule

// File: rtl/fast_timer.sv
module fast_timer #(
  parameter int unsigned TGT_W = timer_bank_pkg::TB_TGT_W,
  parameter int unsigned CNT_W = timer_bank_pkg::TB_CNT_W,
  parameter int unsigned STEP  = timer_bank_pkg::TB_FAST_STEP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o
);
  import timer_bank_pkg::*;

  localparam int unsigned DIV_W = TGT_W + 2;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_nxt;
  logic [DIV_W-1:0] tgt_eff;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             en_rise;
  logic             take;
  fast_state_e      state_q;

  always_comb begin
    tgt_eff = (tgt_i == '0) ? DIV_W'(1) << TGT_W : {2'b00, tgt_i};
    en_rise = en_i & ~en_q;
    take    = (div_q >= tgt_eff);
    div_nxt = div_q + (tick_i ? DIV_W'(STEP) : '0) - (take ? tgt_eff : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      state_q <= FT_IDLE;
    end else begin
      en_q <= en_i;
      if (en_rise) begin
        div_q   <= '0;
        state_q <= FT_IDLE;
      end else if (en_i) begin
        div_q   <= div_nxt;
        state_q <= (div_nxt >= tgt_eff) ? FT_DRAIN : FT_IDLE;
        if (take) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = (state_q == FT_DRAIN);

  // R8: a disabled fast timer keeps divider and counter
  p_hold_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ($stable(cnt_q) && $stable(div_q)));

  // R3: at most one period is removed per cycle
  p_one_step_r3: assert property (@(posedge clk) disable iff (rst)
    (CNT_W'(cnt_q - $past(cnt_q)) <= CNT_W'(1)));

  // R3: no counting while idle with a steady period and no tick
  p_idle_no_count_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !tick_i && $stable(tgt_i)) |=> $stable(cnt_q));
endmodule

// File: rtl/line_timer_bank.sv
module line_timer_bank #(
  parameter int unsigned TGT_W    = timer_bank_pkg::TB_TGT_W,
  parameter int unsigned CNT_W    = timer_bank_pkg::TB_CNT_W,
  parameter int unsigned STEP     = timer_bank_pkg::TB_FAST_STEP,
  parameter int unsigned NUM_SLOW = timer_bank_pkg::TB_NUM_SLOW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_i,
  input  logic                      line_odd_i,
  input  logic                      fast_en_i,
  input  logic [TGT_W-1:0]          fast_tgt_i,
  input  logic [NUM_SLOW-1:0]       slow_en_i,
  input  logic [NUM_SLOW*TGT_W-1:0] slow_tgt_i,
  output logic [CNT_W-1:0]          fast_cnt_o,
  output logic                      fast_busy_o,
  output logic [NUM_SLOW*CNT_W-1:0] slow_cnt_o
);
  logic fast_tick;
  logic slow_tick;

  tick_split u_split (
    .tick_i      (tick_i),
    .line_odd_i  (line_odd_i),
    .fast_tick_o (fast_tick),
    .slow_tick_o (slow_tick)
  );

  fast_timer #(.TGT_W(TGT_W), .CNT_W(CNT_W), .STEP(STEP)) u_fast (
    .clk    (clk),
    .rst    (rst),
    .tick_i (fast_tick),
    .en_i   (fast_en_i),
    .tgt_i  (fast_tgt_i),
    .cnt_o  (fast_cnt_o),
    .busy_o (fast_busy_o)
  );

  for (genvar g = 0; g < NUM_SLOW; g++) begin : g_slow
    slow_timer #(.TGT_W(TGT_W), .CNT_W(CNT_W)) u_slow (
      .clk    (clk),
      .rst    (rst),
      .tick_i (slow_tick),
      .en_i   (slow_en_i[g]),
      .tgt_i  (slow_tgt_i[g*TGT_W +: TGT_W]),
      .cnt_o  (slow_cnt_o[g*CNT_W +: CNT_W])
    );
  end

  // R4: even-line ticks never move the slow counters
  p_even_line_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !line_odd_i) |=> $stable(slow_cnt_o));

  // R1: outputs are cleared in the cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (fast_cnt_o == '0 && slow_cnt_o == '0 && !fast_busy_o));
endmodule

// File: tb/line_timer_bank_tb_top.sv
`timescale 1ns/1ps
module line_timer_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        odd = 1'b0;
  logic        fen = 1'b0;
  logic [7:0]  ftgt = 8'd0;
  logic [1:0]  sen = 2'b00;
  logic [15:0] stgt = 16'd0;
  logic [3:0]  fcnt;
  logic        fbusy;
  logic [7:0]  scnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  line_timer_bank dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .line_odd_i(odd),
    .fast_en_i(fen), .fast_tgt_i(ftgt), .slow_en_i(sen), .slow_tgt_i(stgt),
    .fast_cnt_o(fcnt), .fast_busy_o(fbusy), .slow_cnt_o(scnt)
  );

  // {fast tgt, slow0 tgt, slow1 tgt, ticks, exp fast, exp slow0, exp slow1}
  localparam logic [43:0] VEC [5] = '{
    {8'd3,   8'd2, 8'd5, 8'd10, 4'd13, 4'd2,  4'd1},
    {8'd1,   8'd1, 8'd3, 8'd6,  4'd8,  4'd3,  4'd1},
    {8'd7,   8'd4, 8'd1, 8'd20, 4'd11, 4'd2,  4'd10},
    {8'd0,   8'd0, 8'd2, 8'd70, 4'd1,  4'd0,  4'd1},
    {8'd255, 8'd3, 8'd6, 8'd64, 4'd1,  4'd10, 4'd5}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input logic is_odd, input int gap);
    tick = 1'b1; odd = is_odd;
    @(negedge clk) tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 fast count", fcnt, 0);
    chk("R1 slow counts", scnt, 0);
    chk("R1 busy", fbusy, 0);

    // R2 R5 R6 R7: table-driven runs, lines numbered from 1
    for (int r = 0; r < 5; r++) begin
      ftgt = VEC[r][43:36];
      stgt = {VEC[r][27:20], VEC[r][35:28]};
      fen = 1'b1; sen = 2'b11;
      do_reset();
      for (int t = 1; t <= int'(VEC[r][19:12]); t++) pulse(t % 2 == 1, 7);
      chk($sformatf("R2 R3 R7 fast row %0d", r), fcnt, int'(VEC[r][11:8]));
      chk($sformatf("R5 R6 slow0 row %0d", r), scnt[3:0], int'(VEC[r][7:4]));
      chk($sformatf("R5 R6 slow1 row %0d", r), scnt[7:4], int'(VEC[r][3:0]));
    end

    // R4: even-line ticks ignored, then one odd tick counts
    ftgt = 8'd100; stgt = {8'd1, 8'd1}; fen = 1'b0; sen = 2'b11;
    do_reset();
    repeat (3) pulse(1'b0, 3);
    chk("R4 even ticks slow", scnt, 0);
    pulse(1'b1, 3);
    chk("R4 odd tick slow", scnt, 8'h11);

    // R3: busy and one step per cycle with period 1
    ftgt = 8'd1; fen = 1'b1; sen = 2'b00;
    do_reset();
    tick = 1'b1; odd = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk("R3 busy after tick", fbusy, 1);
    chk("R3 count after tick", fcnt, 0);
    @(negedge clk);
    chk("R3 first step", fcnt, 1);
    repeat (2) @(negedge clk);
    chk("R3 third step", fcnt, 3);
    chk("R3 busy mid drain", fbusy, 1);
    @(negedge clk);
    chk("R3 fourth step", fcnt, 4);
    chk("R3 busy clear", fbusy, 0);

    // R8 R9: hold while disabled, divider cleared on re-enable
    ftgt = 8'd8; fen = 1'b1;
    do_reset();
    pulse(1'b1, 4);
    chk("R9 half period", fcnt, 0);
    fen = 1'b0;
    repeat (2) @(negedge clk);
    repeat (3) pulse(1'b1, 4);
    chk("R8 disabled hold", fcnt, 0);
    fen = 1'b1;
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 tick on enable cycle ignored", fcnt, 0);
    pulse(1'b1, 4);
    chk("R9 divider cleared", fcnt, 0);
    pulse(1'b1, 4);
    chk("R9 full period after re-enable", fcnt, 1);

    finish_run();
  end
endmodule